// File: doc/BRIEF.md
# Isolated Open-Drain Line Repeater Controller

This block is the digital control for one bidirectional open-drain line (a data line, or a clock line that slaves may stretch) carried across an isolation barrier. The barrier is crossed by two unidirectional channels with real propagation delay. One channel runs from side B to side A and the other runs back. On side B the receiver cannot see the repeater's own weak low drive. The sense input therefore reflects only lows from external devices. Side A is a plain open-drain pin whose sense input sees the whole wired line, including the repeater's own drive.

A side-B low that lasts long enough to pass a counting filter is qualified. It then sets a sticky assertion flag. The side-B to side-A channel is driven while the qualified strobe or the flag is active. The flag clears only when the low has made the round trip and returns on the side-A to side-B channel. Short legal pulses are therefore stretched to cover the full turn-on round trip, so no shaved pulse or echo pulse appears. The side-B pin is also driven low by the block while the strobe or flag is set, or while the returning channel is low. This keeps one continuous low on side B. It also passes lows that start on side A through to side B.

The block has no streaming data path. Every pin is a plain level signal. There is no valid/ready handshake and no back-pressure.

Top module: `iso_line_repeater`

## Requirements
- R1: A side-B low (`b_sense_n` = 0) lasting fewer than FILT_CYCLES consecutive clock samples never asserts `ba_tx`. A low lasting FILT_CYCLES samples or more asserts `ba_tx`.
- R2: The rising edge of the qualified strobe sets the assertion flag. The flag stays set after `b_sense_n` returns high, until the synchronized return channel reads low.
- R3: `ba_tx` is high while the qualified strobe or the flag is high. For a qualified pulse, `ba_tx` stays high for at least the B-to-A turn-on delay plus the A-to-B turn-on delay.
- R4: A synchronized low on `ab_rx_n` clears the flag, unless a new qualified rising edge occurs in the same cycle. `ba_tx` falls once the flag is clear and `b_sense_n` is high.
- R5: `b_pull_low` is 1 while the strobe is active, while the flag is set, or while the synchronized `ab_rx_n` is low. The block's own side-B drive never starts a new assertion.
- R6: At the side-A end, `a_pull_low` follows `ba_rx`, and `ab_tx_n` follows `a_sense_n`, each through SYNC_STAGES register stages.
- R7: After the external side-B device releases, the side-B line stays low for at least the B-to-A turn-off delay plus the A-to-B turn-off delay.
- R8: For every side-B pulse that passes the filter, side A and side B each show exactly one falling edge and one rising edge. No echo pulse appears on side B.
- R9: A low that starts on side A drives `b_pull_low` for as long as the return channel stays low. It never sets the flag and never asserts `ba_tx`.
- R10: An active-high synchronous `rst` clears the filter, the flag and all synchronizers. In the cycle after `rst` is sampled, `ba_tx`, `b_pull_low` and `a_pull_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst | input | 1 | Synchronous reset, active high |
| b_sense_n | input | 1 | Side-B receiver output, synchronous to clk; 0 when an external device pulls side B low |
| b_pull_low | output | 1 | 1 drives the side-B pin with the weak low level |
| ba_tx | output | 1 | Side-B to side-A channel input; 1 requests a low on side A |
| ab_rx_n | input | 1 | Side-A to side-B channel output; 0 when side A is low |
| ba_rx | input | 1 | Side-B to side-A channel output at side A |
| a_sense_n | input | 1 | Side-A line level, including the block's own drive; 0 when low |
| a_pull_low | output | 1 | 1 pulls the side-A pin low |
| ab_tx_n | output | 1 | Side-A to side-B channel input; carries the side-A line level |

## Verification
The bench builds the block with FILT_CYCLES = 4 and SYNC_STAGES = 2. Its channel models have asymmetric delays: 5 cycles on and 7 off from B to A, and 6 on and 9 off from A to B. A short filter puts the reject/accept boundary (3 against 4 samples) within a few cycles. The bench can then sweep pulse widths from below that boundary to well beyond the round trip of roughly 20 cycles. Because the turn-on and turn-off delays differ, the stretched-pulse minimum and the release tail can be told apart. Two synchronizer stages on each crossing add latency to the loop, so the flag must bridge a real gap.

// File: rtl/iso_rep_pkg.sv
package iso_rep_pkg;
  // Result of the side-B pulse qualifier.
  typedef struct packed {
    logic valid;       // low has lasted at least the filter length
    logic valid_rise;  // first cycle of valid
  } qual_t;
endpackage

// File: rtl/iso_sync.sv
module iso_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_r;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stage_r <= RST_VAL;
        else     stage_r <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stage_r <= {STAGES{RST_VAL}};
        else     stage_r <= {stage_r[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage_r[STAGES-1];
endmodule

// File: rtl/iso_pulse_qual.sv
module iso_pulse_qual
  import iso_rep_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sense_n,
  output qual_t qual
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_CYCLES);

  logic [CW-1:0] low_cnt;
  logic          valid_q;
  logic          valid;

  always_ff @(posedge clk) begin
    if (rst)               low_cnt <= '0;
    else if (sense_n)      low_cnt <= '0;
    else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
  end

  assign valid = (low_cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid;
  end

  assign qual.valid      = valid;
  assign qual.valid_rise = valid & ~valid_q;

  // R1: a qualified strobe is only ever seen right after a sampled low
  a_r1_valid_after_low: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(!sense_n));
endmodule

// File: rtl/iso_assert_latch.sv
module iso_assert_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic ret_low,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (ret_low) flag <= 1'b0;
  end

  a_r2_set_on_strobe: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);

  a_r2_hold_until_return: assert property (@(posedge clk) disable iff (rst)
    (flag && !ret_low) |=> flag);

  a_r4_clear_on_return: assert property (@(posedge clk) disable iff (rst)
    (ret_low && !set_evt) |=> !flag);
endmodule

// File: rtl/iso_far_end.sv
module iso_far_end #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ba_rx,
  input  logic a_sense_n,
  output logic a_pull_low,
  output logic ab_tx_n
);
  iso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_drv_sync (
    .clk(clk), .rst(rst), .d(ba_rx), .q(a_pull_low)
  );

  iso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lvl_sync (
    .clk(clk), .rst(rst), .d(a_sense_n), .q(ab_tx_n)
  );
endmodule

// File: rtl/iso_line_repeater.sv
module iso_line_repeater
  import iso_rep_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic b_sense_n,
  output logic b_pull_low,
  output logic ba_tx,
  input  logic ab_rx_n,
  input  logic ba_rx,
  input  logic a_sense_n,
  output logic a_pull_low,
  output logic ab_tx_n
);
  qual_t qual;
  logic  flag;
  logic  ret_n_s;
  logic  ret_low;

  iso_pulse_qual #(.FILT_CYCLES(FILT_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .sense_n(b_sense_n), .qual(qual)
  );

  iso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ret_sync (
    .clk(clk), .rst(rst), .d(ab_rx_n), .q(ret_n_s)
  );
  assign ret_low = ~ret_n_s;

  iso_assert_latch u_latch (
    .clk(clk), .rst(rst), .set_evt(qual.valid_rise), .ret_low(ret_low),
    .flag(flag)
  );

  // Channel drive stretched by the flag until the round trip completes.
  assign ba_tx = qual.valid | flag;
  // Weak side-B drive: own assertion plus anything returning from side A.
  assign b_pull_low = qual.valid | flag | ret_low;

  iso_far_end #(.SYNC_STAGES(SYNC_STAGES)) u_far (
    .clk(clk), .rst(rst), .ba_rx(ba_rx), .a_sense_n(a_sense_n),
    .a_pull_low(a_pull_low), .ab_tx_n(ab_tx_n)
  );

  // R10: reset releases every drive in the next cycle
  a_r10_reset_release: assert property (@(posedge clk)
    rst |=> (!ba_tx && !b_pull_low && !a_pull_low));

  // R9: channel drive never starts while side B is sensed idle
  a_r9_no_tx_from_return: assert property (@(posedge clk) disable iff (rst)
    ($rose(ba_tx)) |-> $past(!b_sense_n));
endmodule

// File: tb/iso_line_repeater_tb_top.sv
module iso_line_repeater_tb_top;
  localparam int FILT   = 4;
  localparam int SYNC   = 2;
  localparam int BA_ON  = 5;
  localparam int BA_OFF = 7;
  localparam int AB_ON  = 6;
  localparam int AB_OFF = 9;
  localparam int HLEN   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_b = 1'b0;  // 1 = external device pulls side B low
  logic ext_a = 1'b0;  // 1 = external device pulls side A low

  logic b_sense_n, b_pull_low, ba_tx, ab_rx_n, ba_rx, a_sense_n, a_pull_low, ab_tx_n;
  logic [HLEN-1:0] ba_h = '0;
  logic [HLEN-1:0] ab_h = '0;

  always #4 clk = ~clk;

  // Side B receiver sees only external lows.
  assign b_sense_n = ~ext_b;
  assign a_sense_n = ~(a_pull_low | ext_a);

  // Channel models: rise after ON cycles, fall after OFF cycles.
  always @(posedge clk) begin
    ba_h <= {ba_h[HLEN-2:0], ba_tx};
    ab_h <= {ab_h[HLEN-2:0], ~ab_tx_n};
  end
  assign ba_rx   = |ba_h[BA_OFF-1:BA_ON-1];
  assign ab_rx_n = ~(|ab_h[AB_OFF-1:AB_ON-1]);

  iso_line_repeater #(.FILT_CYCLES(FILT), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .b_sense_n(b_sense_n), .b_pull_low(b_pull_low),
    .ba_tx(ba_tx), .ab_rx_n(ab_rx_n), .ba_rx(ba_rx), .a_sense_n(a_sense_n),
    .a_pull_low(a_pull_low), .ab_tx_n(ab_tx_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Monitor, sampled away from the clock edge.
  int cyc = 0;
  int fa = 0, ra = 0, fb = 0, rb = 0;
  int a_run = 0, b_run = 0, tx_run = 0;
  int a_last = 0, b_last = 0, tx_last = 0, tx_seen = 0;
  int t_rel = 0, t_brise = 0;
  logic a_prev = 1'b1, b_prev = 1'b1, ext_prev = 1'b0;

  always @(posedge clk) begin
    logic a_l, b_l;
    #2;
    cyc++;
    a_l = a_sense_n;
    b_l = ~(ext_b | b_pull_low);
    if (a_prev && !a_l) fa++;
    if (!a_prev && a_l) begin ra++; a_last = a_run; end
    if (b_prev && !b_l) fb++;
    if (!b_prev && b_l) begin rb++; b_last = b_run; t_brise = cyc; end
    a_run = a_l ? 0 : a_run + 1;
    b_run = b_l ? 0 : b_run + 1;
    if (ba_tx) begin tx_run++; tx_seen = 1; end
    else begin if (tx_run != 0) tx_last = tx_run; tx_run = 0; end
    if (ext_prev && !ext_b) t_rel = cyc;
    a_prev = a_l; b_prev = b_l; ext_prev = ext_b;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    fa = 0; ra = 0; fb = 0; rb = 0; tx_seen = 0; tx_last = 0;
    a_last = 0; b_last = 0;
  endtask

  task automatic pulse_b(input int w);
    @(negedge clk); ext_b = 1'b1;
    repeat (w) @(negedge clk);
    ext_b = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(ba_tx == 0, "R10 ba_tx in reset", ba_tx, 0);
    chk(b_pull_low == 0, "R10 b_pull_low in reset", b_pull_low, 0);
    chk(a_pull_low == 0, "R10 a_pull_low in reset", a_pull_low, 0);
  endtask

  task automatic t_reject(input int w);
    clear_mon();
    pulse_b(w);
    chk(tx_seen == 0, "R1 short pulse must not drive channel", tx_seen, 0);
    chk(fa == 0, "R1 no side-A edge for rejected pulse", fa, 0);
    chk(b_pull_low == 0, "R5 no side-B drive left after reject", b_pull_low, 0);
  endtask

  task automatic t_pass(input int w);
    clear_mon();
    pulse_b(w);
    chk(tx_seen == 1, "R1 qualified pulse drives channel", tx_seen, 1);
    chk(tx_last >= BA_ON + AB_ON, "R3 channel drive covers turn-on round trip",
        tx_last, BA_ON + AB_ON);
    chk(fa == 1 && ra == 1, "R8 side-A edge pair", fa * 10 + ra, 11);
    chk(fb == 1 && rb == 1, "R8 side-B edge pair, no echo", fb * 10 + rb, 11);
    chk(t_brise - t_rel >= BA_OFF + AB_OFF, "R7 side-B tail after release",
        t_brise - t_rel, BA_OFF + AB_OFF);
    chk(a_last >= BA_ON + AB_ON, "R2 side-A low stretched by flag", a_last,
        BA_ON + AB_ON);
    chk(ba_tx == 0 && b_pull_low == 0, "R4 all drive released at idle",
        ba_tx * 10 + b_pull_low, 0);
  endtask

  task automatic t_sweep();
    for (int w = FILT; w <= 40; w += 3) t_pass(w);
  endtask

  task automatic t_far_origin();
    clear_mon();
    @(negedge clk); ext_a = 1'b1;
    repeat (20) @(negedge clk);
    chk(b_pull_low == 1, "R9 side-A low drives side B", b_pull_low, 1);
    ext_a = 1'b0;
    repeat (80) @(negedge clk);
    chk(tx_seen == 0, "R9 side-A origin never drives channel", tx_seen, 0);
    chk(fb == 1 && rb == 1, "R9 side-B edge pair for side-A low", fb * 10 + rb, 11);
    chk(fa == 1 && ra == 1, "R6 side-A single low", fa * 10 + ra, 11);
    chk(b_pull_low == 0 && a_pull_low == 0, "R9 no latch after side-A low",
        b_pull_low * 10 + a_pull_low, 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); ext_b = 1'b1;
    repeat (FILT + 1) @(negedge clk);
    ext_b = 1'b0;
    repeat (2) @(negedge clk);
    chk(ba_tx == 1, "R2 flag holds channel after short pulse", ba_tx, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(ba_tx == 0, "R10 reset releases channel", ba_tx, 0);
    chk(b_pull_low == 0, "R10 reset releases side B", b_pull_low, 0);
    rst = 1'b0;
    repeat (80) @(negedge clk);
    chk(ba_tx == 0 && b_pull_low == 0, "R10 idle after mid-pulse reset",
        ba_tx * 10 + b_pull_low, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reject(1);
    t_reject(FILT - 1);
    t_pass(FILT);
    t_sweep();
    t_pass(60);
    t_far_origin();
    t_reset_mid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule